// File: doc/BRIEF.md
# Mantissa-Exponent Baud Rate Generator

This block produces the sampling strobe for an asynchronous serial transmitter and receiver. A fixed prescaler first divides the system clock by sixteen to form a base rate. The base rate is then divided by a programmable factor (N+1)·2^M. N is a 6-bit mantissa and M is a 4-bit exponent. Each completed division emits a single-cycle oversample tick. This tick runs at sixteen times the line bit rate. A second output fires on every sixteenth oversample tick and paces a transmit shifter at the bit rate.

Software loads the 10-bit divisor word through two byte-wide writes. The low byte carries the mantissa and the two low exponent bits. The upper two exponent bits sit in the top two bits of a shared control byte, and the six bits below them belong to other functions. A programmed value goes live only when the current division period ends, so the tick stream never shows a shortened interval. Choosing N and M for a given line rate is done by software.

Top module: `mexp_brg`

## Requirements
- R1: After reset both tick outputs are low and the divisor word is zero (N=0, M=0). Enabling with no writes gives an oversample tick period of 16 clocks.
- R2: With enable held high, the oversample tick repeats every 16·(N+1)·2^M clock cycles. The first tick appears on the (16·(N+1)·2^M − 1)-th rising edge after the first edge that samples enable high.
- R3: Divisor word bits 5:0 hold N and bits 9:6 hold M. A low-byte write sets word bits 7:0 from data bits 7:0. A control-byte write sets word bits 9:8 from data bits 7:6.
- R4: Data bits 5:0 of a control-byte write have no effect on either tick output.
- R5: An exponent of zero is fully supported, giving a period of 16·(N+1) clocks for every N from 0 to 63.
- R6: The bit tick is high only together with an oversample tick, and only on every sixteenth oversample tick counted from enable.
- R7: A divisor written while running takes effect at the next oversample tick. The interval in progress completes with the old value, and the interval after it uses the new value.
- R8: While enable is low, both outputs stay low and all counters are held at zero. The live divisor follows the written registers one cycle later. Raising enable restarts the phase from zero.
- R9: Each tick is a single-cycle pulse. Two oversample ticks are never on adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Global enable of the rate generator |
| lo_wr_i | input | 1 | Write strobe for the divisor low byte |
| lo_data_i | input | 8 | Divisor low byte: N in 5:0, M[1:0] in 7:6 |
| ctl_wr_i | input | 1 | Write strobe for the shared control byte |
| ctl_data_i | input | 8 | Control byte: M[3:2] in 7:6, bits 5:0 unused here |
| os_tick_o | output | 1 | Oversample tick, 16x the bit rate |
| bit_tick_o | output | 1 | Bit-rate tick, every sixteenth oversample tick |

## Verification
A wrong prescaler, mantissa or exponent count shows as a changed interval between oversample ticks. The first interval after enable already exposes it, within one period of 16·(N+1)·2^M clocks. A bad handoff of the live divisor shows on the single interval that straddles a register write: that interval either already uses the new value or stretches. A wrong bit counter shows by the sixteenth oversample tick after enable. Any leak of control bits 5:0 into the divisor changes the very next interval.

// File: rtl/mexp_brg_pkg.sv
`timescale 1ns/1ps
package mexp_brg_pkg;

    // Default geometry of the divisor word and the fixed dividers
    localparam int unsigned DEF_MAN_W      = 6;
    localparam int unsigned DEF_EXP_W      = 4;
    localparam int unsigned DEF_REG_W      = 8;
    localparam int unsigned DEF_BASE_DIV   = 16;
    localparam int unsigned DEF_OS_PER_BIT = 16;

    typedef logic [DEF_REG_W-1:0] reg_byte_t;

endpackage

// File: rtl/mexp_brg_divreg.sv
`timescale 1ns/1ps
module mexp_brg_divreg #(
    parameter int unsigned REG_W = 8,
    parameter int unsigned DIV_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lo_wr_i,
    input  logic [REG_W-1:0] lo_data_i,
    input  logic             ctl_wr_i,
    input  logic [REG_W-1:0] ctl_data_i,
    output logic [DIV_W-1:0] div_word_o
);
    localparam int unsigned HI_W   = DIV_W - REG_W;
    localparam int unsigned HI_POS = REG_W - HI_W;

    typedef struct packed {
        logic [REG_W-1:0] lo;
        logic [HI_W-1:0]  hi;
    } state_t;

    state_t st_d, st_q;
    logic   ctl_unused;

    // Lower control bits belong to other functions of the shared byte
    assign ctl_unused = ^ctl_data_i[HI_POS-1:0];

    always_comb begin
        st_d = st_q;
        if (lo_wr_i) begin
            st_d.lo = lo_data_i;
        end
        if (ctl_wr_i) begin
            st_d.hi = ctl_data_i[REG_W-1:HI_POS];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_word_o = {st_q.hi, st_q.lo};

endmodule

// File: rtl/mexp_brg_base.sv
`timescale 1ns/1ps
module mexp_brg_base #(
    parameter int unsigned DIV = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_pass
            logic base_unused;
            assign base_unused = clk_i ^ rst_ni;
            assign tick_o      = en_i;
        end else begin : g_count
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);

            typedef struct packed {
                logic [CW-1:0] cnt;
            } state_t;

            state_t st_d, st_q;
            logic   last;

            always_comb begin
                st_d = st_q;
                last = (st_q.cnt == LAST);
                if (!en_i) begin
                    st_d.cnt = '0;
                end else if (last) begin
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign tick_o = en_i & last;
        end
    endgenerate

endmodule

// File: rtl/mexp_brg_chain.sv
`timescale 1ns/1ps
module mexp_brg_chain #(
    parameter int unsigned MAN_W = 6,
    parameter int unsigned EXP_W = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   en_i,
    input  logic                   base_tick_i,
    input  logic [MAN_W+EXP_W-1:0] div_word_i,
    output logic                   os_tick_o
);
    localparam int unsigned PRE_W = (1 << EXP_W) - 1;

    typedef struct packed {
        logic [MAN_W-1:0] man_cnt;
        logic [PRE_W-1:0] pre_cnt;
        logic [MAN_W-1:0] act_man;
        logic [EXP_W-1:0] act_exp;
    } state_t;

    state_t           st_d, st_q;
    logic             man_last;
    logic             pre_last;
    logic             man_wrap;
    logic             os_tick;
    logic [PRE_W-1:0] pre_lim;
    logic [PRE_W-1:0] all_ones;

    always_comb begin
        st_d     = st_q;
        all_ones = '1;
        pre_lim  = ~(all_ones << st_q.act_exp);
        man_last = (st_q.man_cnt == st_q.act_man);
        pre_last = (st_q.pre_cnt == pre_lim);
        man_wrap = base_tick_i & man_last;
        os_tick  = man_wrap & pre_last;

        if (!en_i) begin
            st_d.man_cnt = '0;
            st_d.pre_cnt = '0;
            st_d.act_man = div_word_i[MAN_W-1:0];
            st_d.act_exp = div_word_i[MAN_W+EXP_W-1:MAN_W];
        end else begin
            if (base_tick_i) begin
                st_d.man_cnt = man_last ? '0 : st_q.man_cnt + MAN_W'(1);
            end
            if (man_wrap) begin
                st_d.pre_cnt = pre_last ? '0 : st_q.pre_cnt + PRE_W'(1);
            end
            // Divisor handoff only at terminal count
            if (os_tick) begin
                st_d.act_man = div_word_i[MAN_W-1:0];
                st_d.act_exp = div_word_i[MAN_W+EXP_W-1:MAN_W];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign os_tick_o = os_tick;

endmodule

// File: rtl/mexp_brg_bitdiv.sv
`timescale 1ns/1ps
module mexp_brg_bitdiv #(
    parameter int unsigned RATIO = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic os_tick_i,
    output logic bit_tick_o
);
    generate
        if (RATIO <= 1) begin : g_pass
            logic bit_unused;
            assign bit_unused = clk_i ^ rst_ni ^ en_i;
            assign bit_tick_o = os_tick_i;
        end else begin : g_count
            localparam int unsigned CW = $clog2(RATIO);
            localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

            typedef struct packed {
                logic [CW-1:0] cnt;
            } state_t;

            state_t st_d, st_q;
            logic   last;

            always_comb begin
                st_d = st_q;
                last = (st_q.cnt == LAST);
                if (!en_i) begin
                    st_d.cnt = '0;
                end else if (os_tick_i) begin
                    st_d.cnt = last ? '0 : st_q.cnt + CW'(1);
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign bit_tick_o = os_tick_i & last;
        end
    endgenerate

endmodule

// File: rtl/mexp_brg.sv
`timescale 1ns/1ps
module mexp_brg #(
    parameter int unsigned MAN_W      = mexp_brg_pkg::DEF_MAN_W,
    parameter int unsigned EXP_W      = mexp_brg_pkg::DEF_EXP_W,
    parameter int unsigned REG_W      = mexp_brg_pkg::DEF_REG_W,
    parameter int unsigned BASE_DIV   = mexp_brg_pkg::DEF_BASE_DIV,
    parameter int unsigned OS_PER_BIT = mexp_brg_pkg::DEF_OS_PER_BIT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             lo_wr_i,
    input  logic [REG_W-1:0] lo_data_i,
    input  logic             ctl_wr_i,
    input  logic [REG_W-1:0] ctl_data_i,
    output logic             os_tick_o,
    output logic             bit_tick_o
);
    localparam int unsigned DIV_W = MAN_W + EXP_W;

    logic [DIV_W-1:0] div_word;
    logic             base_tick;
    logic             os_tick;
    logic             bit_tick;

    mexp_brg_divreg #(
        .REG_W (REG_W),
        .DIV_W (DIV_W)
    ) u_divreg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .lo_wr_i    (lo_wr_i),
        .lo_data_i  (lo_data_i),
        .ctl_wr_i   (ctl_wr_i),
        .ctl_data_i (ctl_data_i),
        .div_word_o (div_word)
    );

    mexp_brg_base #(
        .DIV (BASE_DIV)
    ) u_base (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .tick_o (base_tick)
    );

    mexp_brg_chain #(
        .MAN_W (MAN_W),
        .EXP_W (EXP_W)
    ) u_chain (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .base_tick_i (base_tick),
        .div_word_i  (div_word),
        .os_tick_o   (os_tick)
    );

    mexp_brg_bitdiv #(
        .RATIO (OS_PER_BIT)
    ) u_bitdiv (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .os_tick_i  (os_tick),
        .bit_tick_o (bit_tick)
    );

    assign os_tick_o  = os_tick;
    assign bit_tick_o = bit_tick;

endmodule

// File: rtl/mexp_brg_chk.sv
`timescale 1ns/1ps
module mexp_brg_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic base_tick,
    input logic os_tick_o,
    input logic bit_tick_o
);
    // R6: bit tick only together with an oversample tick
    assert_bit_in_os_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_tick_o |-> os_tick_o);

    // R8: no tick in the cycle after enable was low
    assert_quiet_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(en_i) |-> !os_tick_o && !bit_tick_o);

    // R9: ticks are single-cycle pulses
    assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        os_tick_o |=> !os_tick_o);

    // R2: every oversample tick closes a base period
    assert_on_base_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        os_tick_o |-> base_tick);

    // R8: a freshly raised enable never ticks at once
    assert_rise_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(en_i) |-> !os_tick_o);

endmodule

bind mexp_brg mexp_brg_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .base_tick  (base_tick),
    .os_tick_o  (os_tick_o),
    .bit_tick_o (bit_tick_o)
);

// File: tb/mexp_brg_tb.sv
`timescale 1ns/1ps
module mexp_brg_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic       lo_wr;
    logic       ctl_wr;
    logic [7:0] lo_d;
    logic [7:0] ctl_d;
    logic       os_tick;
    logic       bit_tick;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    always #2.5 clk = ~clk;

    mexp_brg u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .lo_wr_i    (lo_wr),
        .lo_data_i  (lo_d),
        .ctl_wr_i   (ctl_wr),
        .ctl_data_i (ctl_d),
        .os_tick_o  (os_tick),
        .bit_tick_o (bit_tick)
    );

    // Vector table: low byte, control byte, expected period, requirement
    localparam int NV = 7;
    localparam logic [7:0] V_LO  [NV] = '{8'h00, 8'h01, 8'h42, 8'h3F, 8'h00, 8'h82, 8'h80};
    localparam logic [7:0] V_CTL [NV] = '{8'h00, 8'h3F, 8'h00, 8'h00, 8'h40, 8'h15, 8'h40};
    localparam int         V_P   [NV] = '{16, 32, 96, 1024, 256, 192, 1024};
    localparam string      V_REQ [NV] = '{"R5", "R4", "R3", "R5", "R3", "R3", "R3"};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_lo(input logic [7:0] v);
        lo_d = v; lo_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        lo_wr = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_d = v; ctl_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    // Counts rising edges until an oversample tick is seen at a falling edge
    task automatic next_tick(output int n, output logic b);
        n = 0;
        do begin
            @(posedge clk); @(negedge clk);
            n++;
        end while (!os_tick && n < 20000);
        b = bit_tick;
    endtask

    initial begin
        int   n;
        logic b;
        bit   quiet;
        rst_n = 1'b0; en = 1'b0; lo_wr = 1'b0; ctl_wr = 1'b0;
        lo_d = '0; ctl_d = '0;
        idle(3);
        check(!os_tick && !bit_tick, "R1 outputs in reset", {os_tick, bit_tick}, 0);
        rst_n = 1'b1;
        idle(2);
        check(!os_tick && !bit_tick, "R1 outputs after reset", {os_tick, bit_tick}, 0);
        en = 1'b1;
        next_tick(n, b);
        check(n == 15, "R1 default divisor first tick", n, 15);
        next_tick(n, b);
        check(n == 16, "R1 default divisor period", n, 16);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            en = 1'b0;
            idle(2);
            wr_lo(V_LO[i]);
            wr_ctl(V_CTL[i]);
            idle(2);
            en = 1'b1;
            next_tick(n, b);
            check(n == V_P[i] - 1, {V_REQ[i], " R2 first tick"}, n, V_P[i] - 1);
            check(b == 1'b0, "R6 no bit tick on first", b, 0);
            for (int k = 2; k <= 16; k++) begin
                next_tick(n, b);
                check(n == V_P[i], {V_REQ[i], " R2 period"}, n, V_P[i]);
                check(b == (k == 16), "R6 bit tick on sixteenth", b, (k == 16));
            end
        end

        // R7: change divisor mid-run, P 32 -> 96
        en = 1'b0;
        idle(2);
        wr_lo(8'h01);
        wr_ctl(8'h00);
        idle(2);
        en = 1'b1;
        next_tick(n, b);
        check(n == 31, "R7 setup first tick", n, 31);
        lo_d = 8'h42; lo_wr = 1'b1;
        next_tick(n, b);
        lo_wr = 1'b0;
        check(n == 32, "R7 interval in progress keeps old", n, 32);
        next_tick(n, b);
        check(n == 96, "R7 new divisor after terminal count", n, 96);

        // R4: control low bits ignored while running
        ctl_d = 8'h3F; ctl_wr = 1'b1;
        next_tick(n, b);
        check(n == 96, "R4 ctl low bits ignored", n, 96);
        ctl_d = 8'h2A;
        next_tick(n, b);
        ctl_wr = 1'b0;
        check(n == 96, "R4 ctl low bits ignored again", n, 96);

        // R9: pulse is one cycle wide
        idle(1);
        check(!os_tick, "R9 single cycle tick", os_tick, 0);

        // R8: disable mid-interval, stay quiet, restart from phase zero
        idle(40);
        en = 1'b0;
        quiet = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); @(negedge clk);
            if (os_tick || bit_tick) quiet = 1'b0;
        end
        check(quiet, "R8 quiet while disabled", quiet, 1);
        wr_lo(8'h00);
        idle(2);
        en = 1'b1;
        next_tick(n, b);
        check(n == 15, "R8 restart from zero phase", n, 15);
        next_tick(n, b);
        check(n == 16, "R8 restart period", n, 16);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule